// File: doc/BRIEF.md
# Single-Port Memory with Lane-Masked Writes

This block is a one-clock, one-port memory array with a selectable pipeline around it. When the block is built, three port groups can each be given a register or passed straight through. The groups are the write group (write data, write strobe and lane mask), the address, and the read word. Every write can be restricted to a subset of lanes. A lane is a slice of the data word whose width is a parameter.

The input-side registers and the memory access are gated by one clock enable. The read-word register is gated either by its own enable or by that same input enable, chosen when the block is built. A stall input freezes the captured address, so a host can hold the current access while presenting the next address. An asynchronous clear zeroes the pipeline registers and leaves the stored words intact. The block is meant for datapaths that need a fixed, known read latency and sub-word updates.

Top module: `spram_be`

## Requirements
- R1: The word holds DATA_W/BYTE_W lanes. Lane k is bits [k*BYTE_W +: BYTE_W] and is governed by `byte_en[k]`. BYTE_W must be 5, 8, 9 or 10, and DATA_W must be an exact multiple of it. Any other choice is refused at elaboration.
- R2: A write changes only the lanes whose `byte_en` bit is 1. Every other lane of that word keeps its stored value, and a write with an all-zero mask changes nothing.
- R3: After the address settles, the read word appears at `rdata` exactly A+1+O rising edges later. A is 1 when the address is registered and 0 otherwise. O is 1 when the read word is registered and 0 otherwise.
- R4: A write returns the word stored before the write on its access edge. The new word is seen only on the following access.
- R5: A registered write group adds one edge between presenting `wen`/`wdata`/`byte_en` and the array update. An unregistered group updates the array on the first edge.
- R6: While `ce_in` is 0, there are no array writes, the input-side registers hold, and the array read register holds.
- R7: In split-enable mode, `ce_out` alone gates the read-word register, and `rdata` holds while `ce_out` is 0.
- R8: In shared-enable mode, `ce_out` has no effect and `ce_in` gates the read-word register.
- R9: With a registered address, `addr_hold`=1 keeps the captured address and the block keeps reading that word. With an unregistered address, `addr_hold` has no effect.
- R10: `clr`=1 drives the read-word register to zero at once, without waiting for a clock edge. It also zeroes the write-group and address registers.
- R11: `clr` never changes stored words. With no read-word register, `clr` leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers and the array use the rising edge |
| clr | input | 1 | Asynchronous active-high clear of the pipeline registers |
| ce_in | input | 1 | Enable for the write-group and address registers and for the array access |
| ce_out | input | 1 | Enable for the read-word register in split-enable mode |
| addr_hold | input | 1 | 1 keeps the captured address, 0 loads normally |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write word |
| wen | input | 1 | Write strobe |
| byte_en | input | DATA_W/BYTE_W | Lane write mask, bit k for lane k |
| rdata | output | DATA_W | Read word |

## Verification
The bench builds nine copies side by side with 27-bit words and 9-bit lanes, so there are three lanes of a width that is not a power of two. Eight copies use split enables and cover every combination of the three registering choices. This lets one shared stimulus stream measure the latency of every pipeline shape edge by edge. The ninth copy registers all three groups and shares one enable between both sides. Only that copy separates the two enable modes, and the bench does this by clearing its read register while `ce_in` is low.

// File: rtl/spram_be_pkg.sv
package spram_be_pkg;

    // Whether a port group gets a register or passes straight through
    typedef enum logic {
        STAGE_PASS = 1'b0,
        STAGE_REG  = 1'b1
    } stage_e;

    // Whether the read-word register owns an enable or shares ce_in
    typedef enum logic {
        CE_SHARED = 1'b0,
        CE_SPLIT  = 1'b1
    } ce_mode_e;

    // Lane widths the array supports
    function automatic bit lane_width_ok(input int unsigned bw);
        return (bw == 5) || (bw == 8) || (bw == 9) || (bw == 10);
    endfunction

    function automatic int unsigned lane_count(input int unsigned dw, input int unsigned bw);
        return (bw == 0) ? 1 : ((dw / bw) == 0 ? 1 : dw / bw);
    endfunction

endpackage

// File: rtl/spram_be_stage.sv
module spram_be_stage #(
    parameter int unsigned          WIDTH = 8,
    parameter spram_be_pkg::stage_e MODE  = spram_be_pkg::STAGE_REG
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    if (MODE == spram_be_pkg::STAGE_REG) begin : g_reg
        logic [WIDTH-1:0] q_r;

        always_ff @(posedge clk or posedge clr) begin
            if (clr) begin
                q_r <= '0;
            end else if (en) begin
                q_r <= d;
            end
        end

        assign q = q_r;

        // R10: a clear seen at an edge leaves the register at zero for the cycle
        assert_clear_zeroes_R10: assert property (@(posedge clk)
            clr |=> q_r == '0);

        // R6: a disabled stage keeps its value (a mid-cycle clear may zero it)
        assert_idle_stage_holds_R6: assert property (@(posedge clk) disable iff (clr)
            !en |=> (q_r == $past(q_r)) || (q_r == '0));
    end else begin : g_pass
        logic unused_pass;
        assign unused_pass = ^{clk, clr, en};
        assign q = d;
    end

endmodule

// File: rtl/spram_be_array.sv
module spram_be_array #(
    parameter  int unsigned DATA_W = 32,
    parameter  int unsigned BYTE_W = 8,
    parameter  int unsigned ADDR_W = 6,
    localparam int unsigned LANES  = spram_be_pkg::lane_count(DATA_W, BYTE_W),
    localparam int unsigned DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  lane_en,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q;
    logic              wr_go;

    // No write is issued on an edge that sees the clear
    assign wr_go = en & we & ~clr;

    always_ff @(posedge clk) begin
        if (wr_go) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_en[l]) begin
                    mem[addr][l*BYTE_W +: BYTE_W] <= wdata[l*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    // Read register samples the word before this edge's write lands
    always_ff @(posedge clk) begin
        if (en) begin
            rd_q <= mem[addr];
        end
    end

    assign rdata = rd_q;

    // R4: the access edge of a write returns the prior word
    assert_read_prior_word_R4: assert property (@(posedge clk)
        wr_go |=> rd_q == $past(mem[addr]));

    // R11: clearing never touches stored words
    assert_clear_keeps_array_R11: assert property (@(posedge clk)
        clr |=> mem[$past(addr)] == $past(mem[addr]));

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        // R2: a masked-off lane keeps its contents
        assert_masked_lane_kept_R2: assert property (@(posedge clk)
            (wr_go && !lane_en[l]) |=>
                mem[$past(addr)][l*BYTE_W +: BYTE_W] == $past(mem[addr][l*BYTE_W +: BYTE_W]));

        // R2: an enabled lane takes the write data
        assert_enabled_lane_written_R2: assert property (@(posedge clk)
            (wr_go && lane_en[l]) |=>
                mem[$past(addr)][l*BYTE_W +: BYTE_W] == $past(wdata[l*BYTE_W +: BYTE_W]));
    end

endmodule

// File: rtl/spram_be.sv
module spram_be #(
    parameter  int unsigned            DATA_W     = 32,
    parameter  int unsigned            BYTE_W     = 8,
    parameter  int unsigned            ADDR_W     = 6,
    parameter  spram_be_pkg::stage_e   WR_STAGE   = spram_be_pkg::STAGE_REG,
    parameter  spram_be_pkg::stage_e   ADDR_STAGE = spram_be_pkg::STAGE_REG,
    parameter  spram_be_pkg::stage_e   OUT_STAGE  = spram_be_pkg::STAGE_REG,
    parameter  spram_be_pkg::ce_mode_e CE_MODE    = spram_be_pkg::CE_SPLIT,
    localparam int unsigned            LANES      = spram_be_pkg::lane_count(DATA_W, BYTE_W),
    localparam int unsigned            WG_W       = 1 + LANES + DATA_W
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              ce_in,
    input  logic              ce_out,
    input  logic              addr_hold,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wen,
    input  logic [LANES-1:0]  byte_en,
    output logic [DATA_W-1:0] rdata
);
    import spram_be_pkg::*;

    // R1: lane width and word width must agree
    if (!lane_width_ok(BYTE_W) || (DATA_W % BYTE_W) != 0) begin : g_bad_cfg
        $error("spram_be: lane width %0d unsupported or does not divide word width %0d",
               BYTE_W, DATA_W);
    end

    logic [WG_W-1:0]   wg_d;
    logic [WG_W-1:0]   wg_q;
    logic              wen_s;
    logic [LANES-1:0]  be_s;
    logic [DATA_W-1:0] wdata_s;
    logic [ADDR_W-1:0] addr_q;
    logic              addr_en;
    logic [DATA_W-1:0] arr_q;
    logic              out_en;

    // Write group: strobe, lane mask and data travel together
    assign wg_d = {wen, byte_en, wdata};

    spram_be_stage #(
        .WIDTH (WG_W),
        .MODE  (WR_STAGE)
    ) u_wr_stage (
        .clk (clk),
        .clr (clr),
        .en  (ce_in),
        .d   (wg_d),
        .q   (wg_q)
    );

    assign {wen_s, be_s, wdata_s} = wg_q;

    // Address: the stall acts as a second, inverted enable
    assign addr_en = ce_in & ~addr_hold;

    spram_be_stage #(
        .WIDTH (ADDR_W),
        .MODE  (ADDR_STAGE)
    ) u_addr_stage (
        .clk (clk),
        .clr (clr),
        .en  (addr_en),
        .d   (addr),
        .q   (addr_q)
    );

    spram_be_array #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W),
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk     (clk),
        .clr     (clr),
        .en      (ce_in),
        .we      (wen_s),
        .addr    (addr_q),
        .wdata   (wdata_s),
        .lane_en (be_s),
        .rdata   (arr_q)
    );

    assign out_en = (CE_MODE == CE_SPLIT) ? ce_out : ce_in;

    spram_be_stage #(
        .WIDTH (DATA_W),
        .MODE  (OUT_STAGE)
    ) u_out_stage (
        .clk (clk),
        .clr (clr),
        .en  (out_en),
        .d   (arr_q),
        .q   (rdata)
    );

    if (ADDR_STAGE == STAGE_REG) begin : g_stall_chk
        // R9: a stalled address register keeps the captured address
        assert_stall_keeps_address_R9: assert property (@(posedge clk) disable iff (clr)
            addr_hold |=> (addr_q == $past(addr_q)) || (addr_q == '0));
    end

    if (OUT_STAGE == STAGE_REG && CE_MODE == CE_SPLIT) begin : g_split_chk
        // R7: rdata frozen while the output enable is low
        assert_split_output_frozen_R7: assert property (@(posedge clk) disable iff (clr)
            !ce_out |=> (rdata == $past(rdata)) || (rdata == '0));
    end

    if (OUT_STAGE == STAGE_REG && CE_MODE == CE_SHARED) begin : g_shared_chk
        // R8: in shared mode the input enable gates the read word
        assert_shared_output_frozen_R8: assert property (@(posedge clk) disable iff (clr)
            !ce_in |=> (rdata == $past(rdata)) || (rdata == '0));
    end

endmodule

// File: tb/test_spram_be.sv
module test_spram_be;
    import spram_be_pkg::*;

    localparam int unsigned DW = 27;
    localparam int unsigned BW = 9;
    localparam int unsigned AW = 4;
    localparam int unsigned LN = DW / BW;
    localparam int unsigned NI = 9;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [LN-1:0] be;
        logic [DW-1:0] d;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{4'd0,  3'b111, 27'h1234567},
        '{4'd5,  3'b111, 27'h7654321},
        '{4'd9,  3'b111, 27'h2AAAAAA},
        '{4'd15, 3'b111, 27'h5555555},
        '{4'd5,  3'b001, 27'h0000000},
        '{4'd9,  3'b010, 27'h7FFFFFF},
        '{4'd15, 3'b100, 27'h0ABCDEF},
        '{4'd0,  3'b000, 27'h7FFFFFF},
        '{4'd5,  3'b110, 27'h3C0FFEE},
        '{4'd3,  3'b111, 27'h1F2E3D4}
    };

    logic          clk = 1'b0;
    logic          clr = 1'b1;
    logic          ce_in = 1'b1;
    logic          ce_out = 1'b1;
    logic          addr_hold = 1'b0;
    logic          wen = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [LN-1:0] byte_en = '0;
    logic [DW-1:0] rd [NI];
    logic [DW-1:0] ref_mem [1 << AW];

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // Configuration of copy i: bit0 write group, bit1 address, bit2 read word
    function automatic int wr_reg(input int i);   return (i < 8) ? (i % 2) : 1;       endfunction
    function automatic int addr_reg(input int i); return (i < 8) ? ((i / 2) % 2) : 1; endfunction
    function automatic int out_reg(input int i);  return (i < 8) ? ((i / 4) % 2) : 1; endfunction
    function automatic int split_ce(input int i); return (i < 8) ? 1 : 0;             endfunction
    function automatic int lat(input int i);      return addr_reg(i) + 1 + out_reg(i); endfunction

    for (genvar g = 0; g < 8; g++) begin : g_cfg
        spram_be #(
            .DATA_W     (DW),
            .BYTE_W     (BW),
            .ADDR_W     (AW),
            .WR_STAGE   ((g % 2) == 1 ? STAGE_REG : STAGE_PASS),
            .ADDR_STAGE (((g / 2) % 2) == 1 ? STAGE_REG : STAGE_PASS),
            .OUT_STAGE  (((g / 4) % 2) == 1 ? STAGE_REG : STAGE_PASS),
            .CE_MODE    (CE_SPLIT)
        ) i_spram_be (
            .clk       (clk),
            .clr       (clr),
            .ce_in     (ce_in),
            .ce_out    (ce_out),
            .addr_hold (addr_hold),
            .addr      (addr),
            .wdata     (wdata),
            .wen       (wen),
            .byte_en   (byte_en),
            .rdata     (rd[g])
        );
    end

    spram_be #(
        .DATA_W     (DW),
        .BYTE_W     (BW),
        .ADDR_W     (AW),
        .WR_STAGE   (STAGE_REG),
        .ADDR_STAGE (STAGE_REG),
        .OUT_STAGE  (STAGE_REG),
        .CE_MODE    (CE_SHARED)
    ) i_spram_be_shared (
        .clk       (clk),
        .clr       (clr),
        .ce_in     (ce_in),
        .ce_out    (ce_out),
        .addr_hold (addr_hold),
        .addr      (addr),
        .wdata     (wdata),
        .wen       (wen),
        .byte_en   (byte_en),
        .rdata     (rd[8])
    );

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [LN-1:0] m);
        logic [DW-1:0] r;
        r = old_w;
        for (int k = 0; k < LN; k++) begin
            if (m[k]) r[k*BW +: BW] = new_w[k*BW +: BW];
        end
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int inst,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s copy %0d: rdata=%h expected %h", req, inst, act, exp);
        end
    endtask

    task automatic write_word(input logic [AW-1:0] a, input logic [LN-1:0] m,
                              input logic [DW-1:0] d, input bit upd);
        addr = a;
        wen  = 1'b0;
        tick();
        tick();
        wdata   = d;
        byte_en = m;
        wen     = 1'b1;
        tick();
        tick();
        wen = 1'b0;
        tick();
        tick();
        if (upd) ref_mem[a] = merge(ref_mem[a], d, m);
    endtask

    task automatic read_all(input logic [AW-1:0] a, input string req);
        addr = a;
        wen  = 1'b0;
        repeat (4) tick();
        for (int i = 0; i < NI; i++) check(req, i, rd[i], ref_mem[a]);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] old_w;
        logic [DW-1:0] new_w;
        logic [DW-1:0] exp;

        // R10: reset state of the registered read word
        repeat (3) tick();
        for (int i = 0; i < NI; i++) begin
            if (out_reg(i) == 1) check("R10 reset", i, rd[i], '0);
        end
        clr = 1'b0;
        tick();

        // R1 R2: table of lane-masked writes, each read back on every copy
        for (int v = 0; v < 10; v++) begin
            write_word(VECS[v].a, VECS[v].be, VECS[v].d, 1'b1);
            read_all(VECS[v].a, "R1 R2 lane write");
        end

        // R3: edge-exact latency per pipeline shape, address 5 -> 9
        read_all(4'd5, "R3 settle");
        addr = 4'd9;
        for (int k = 1; k <= 4; k++) begin
            tick();
            for (int i = 0; i < NI; i++) begin
                exp = (k >= lat(i)) ? ref_mem[9] : ref_mem[5];
                check("R3 latency", i, rd[i], exp);
            end
        end

        // R4 R5: write over a settled address, old word first, new word one access later
        old_w   = ref_mem[9];
        new_w   = 27'h0F0F0F0;
        wdata   = new_w;
        byte_en = 3'b111;
        wen     = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            tick();
            for (int i = 0; i < NI; i++) begin
                exp = (k >= wr_reg(i) + 2 + out_reg(i)) ? new_w : old_w;
                check("R4 R5 read-before-write", i, rd[i], exp);
            end
        end
        wen = 1'b0;
        ref_mem[9] = new_w;
        tick();
        tick();

        // R6: writes with ce_in low are dropped
        ce_in = 1'b0;
        write_word(4'd3, 3'b111, 27'h0000111, 1'b0);
        ce_in = 1'b1;
        read_all(4'd3, "R6 ce_in blocks write");

        // R7: ce_out low freezes split registered outputs only
        read_all(4'd0, "R7 settle");
        ce_out = 1'b0;
        addr   = 4'd15;
        repeat (4) tick();
        for (int i = 0; i < NI; i++) begin
            exp = (out_reg(i) == 1 && split_ce(i) == 1) ? ref_mem[0] : ref_mem[15];
            check("R7 ce_out hold", i, rd[i], exp);
        end
        ce_out = 1'b1;
        tick();
        for (int i = 0; i < NI; i++) check("R7 ce_out release", i, rd[i], ref_mem[15]);

        // R10 R11 R8: mid-cycle clear with ce_in low
        ce_in = 1'b0;
        clr   = 1'b1;
        #1;
        for (int i = 0; i < NI; i++) begin
            if (out_reg(i) == 1) check("R10 async clear", i, rd[i], '0);
            else                 check("R11 clear leaves unregistered rdata", i, rd[i], ref_mem[15]);
        end
        #1;
        clr = 1'b0;
        tick();
        for (int i = 0; i < NI; i++) begin
            exp = (split_ce(i) == 0) ? '0 : ref_mem[15];
            check("R8 enable mode after clear", i, rd[i], exp);
        end
        ce_in = 1'b1;

        // R11: stored words survive the clear
        read_all(4'd0,  "R11 contents kept");
        read_all(4'd3,  "R11 contents kept");
        read_all(4'd5,  "R11 contents kept");
        read_all(4'd9,  "R11 contents kept");
        read_all(4'd15, "R11 contents kept");

        // R9: address stall, effective only with a registered address
        read_all(4'd0, "R9 settle");
        addr_hold = 1'b1;
        addr      = 4'd5;
        repeat (4) tick();
        for (int i = 0; i < NI; i++) begin
            exp = (addr_reg(i) == 1) ? ref_mem[0] : ref_mem[5];
            check("R9 stall", i, rd[i], exp);
        end
        addr_hold = 1'b0;
        repeat (4) tick();
        for (int i = 0; i < NI; i++) check("R9 stall release", i, rd[i], ref_mem[5]);

        done = 1'b1;
        report();
        $finish;
    end

endmodule